// File: doc/BRIEF.md
# Value-Compare Store-Conditional Unit

This block provides linked-load / store-conditional on the requesting side, with success decided by comparing data values instead of by a reservation key. A linked load acts as an ordinary read. The block keeps a link register that holds the address, the data that was read, a valid bit and a flag for 64-bit width. A second linked load to the same linked location is served from the link register and causes no memory traffic.

A store-conditional that hits the link register builds a flit packet. The packet carries the data read earlier, followed by the data to store. A small memory-side unit in the same block receives the packet. It reads the current content and stores the new data only when the content still equals the old data. It returns 0 for success and 1 for failure, and the requester passes that bit to the core. A store-conditional that misses fails at once and sends no packet. Every store-conditional clears the link register. Plain stores and reads, which stand in for other agents and for coherence traffic, leave the link register as it is.

The packet flits are brought out as outputs so that the traffic between the two halves can be observed.

Top module: `cmp_sc_unit`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `pkt_valid` are 0, memory words read as 0, and the link register is empty, so a store-conditional fails (fail=1) without a packet.
- R2: A linked load (op 0) whose address and width both match a valid link register returns the stored data with no packet.
- R3: A linked load that misses sends a one-flit read packet, stores the returned data together with the address and width, sets the link valid and returns the data.
- R4: A store-conditional (op 1) that hits the link register sends a packet and returns the memory side's result. One that misses returns fail=1 with no packet.
- R5: The link register is invalid after every store-conditional, whether it succeeded, failed at the memory, or missed locally.
- R6: A store-conditional packet has 2 flits (old, new) for a 32-bit access and 4 flits (old-low, old-high, new-low, new-high) for a 64-bit access.
- R7: The memory side stores the new data only if the current content equals the old data (both halves for 64-bit), and answers 0 on success and 1 on failure.
- R8: Plain stores (op 2) and plain reads (op 3) never change the link register. After a store of a different value, a store-conditional fails. After a store of the same value, it succeeds.
- R9: A 64-bit access covers word `addr` (low half) and word `addr+1` (high half). A 32-bit read returns the word zero-extended. Stores answer fail=0 and data 0, with 1 flit for 32-bit and 2 flits for 64-bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core request strobe |
| req_op | input | 2 | 0 linked load, 1 store-conditional, 2 store, 3 read |
| req_long | input | 1 | 1 for a 64-bit access |
| req_addr | input | AW | Word address |
| req_wdata | input | 64 | Store data (low 32 bits used for 32-bit) |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 64 | Read data, zero-extended for 32-bit |
| rsp_fail | output | 1 | Store-conditional result, 1 = failure |
| pkt_valid | output | 1 | A flit is on the packet channel |
| pkt_last | output | 1 | Last flit of the packet |
| pkt_data | output | 32 | Flit payload |

## Verification
The assertions check on every cycle that a store-conditional leaves the link invalid, that a local hit or a local miss produces no packet, that a store-conditional packet has the right flit count, and that a failure answer only comes from a compare that failed. Only the bench's scenarios can show the end-to-end value semantics. These include a stale hit after another store, the same-value store that still lets the store-conditional succeed, the link register being replaced by a linked load to another location, and the flit ordering seen against the memory content.

// File: rtl/cmpsc_pkg.sv
// Shared types for the value-compare store-conditional unit.
// Assumes a 32-bit memory word; 64-bit accesses use two words.
package cmpsc_pkg;
    localparam int WORD_W = 32;
    localparam int MAX_FLITS = 4;

    // Core request codes; the packet channel reuses RD, WR and SC.
    typedef enum logic [1:0] {
        OP_LL = 2'd0,
        OP_SC = 2'd1,
        OP_WR = 2'd2,
        OP_RD = 2'd3
    } op_e;
endpackage

// File: rtl/ll_link_unit.sv
// Requester half: owns the link register, answers linked-load hits
// locally and serialises read, store and store-conditional packets.
// Assumes one request in flight; the core waits for rsp_valid.
module ll_link_unit
    import cmpsc_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic              req_long,
    input  logic [AW-1:0]     req_addr,
    input  logic [63:0]       req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [63:0]       rsp_data,
    output logic              rsp_fail,
    output logic              pkt_valid,
    output logic [1:0]        pkt_op,
    output logic [AW-1:0]     pkt_addr,
    output logic              pkt_long,
    output logic              pkt_last,
    output logic [WORD_W-1:0] pkt_data,
    input  logic              mrsp_valid,
    input  logic [63:0]       mrsp_data,
    input  logic              mrsp_fail
);
    localparam int IW = $clog2(MAX_FLITS);

    typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT} st_e;

    st_e               st;
    logic              link_vld;
    logic [AW-1:0]     link_addr;
    logic              link_long;
    logic [63:0]       link_data;
    logic              fill_link;
    logic [WORD_W-1:0] fbuf [MAX_FLITS];
    logic [IW-1:0]     fidx;
    logic [IW:0]       nflit;
    logic              accept;
    logic              hit;

    // Request handshake and link lookup.
    assign req_ready = (st == S_IDLE) && !rsp_valid;
    assign accept    = req_valid && req_ready;
    assign hit       = link_vld && (link_addr == req_addr) && (link_long == req_long);

    // Packet channel driven from the held flit buffer.
    assign pkt_valid = (st == S_SEND);
    assign pkt_data  = fbuf[fidx];
    assign pkt_last  = ({1'b0, fidx} == nflit - 1'b1);

    // Main control: accept, serialise, collect memory answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            link_vld  <= 1'b0;
            link_addr <= '0;
            link_long <= 1'b0;
            link_data <= '0;
            fill_link <= 1'b0;
            fidx      <= '0;
            nflit     <= '0;
            pkt_op    <= OP_RD;
            pkt_addr  <= '0;
            pkt_long  <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_fail  <= 1'b0;
            for (int i = 0; i < MAX_FLITS; i++) fbuf[i] <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (st)
                S_IDLE: if (accept) begin
                    pkt_addr  <= req_addr;
                    pkt_long  <= req_long;
                    fill_link <= 1'b0;
                    fidx      <= '0;
                    case (op_e'(req_op))
                        OP_LL: if (hit) begin
                            rsp_valid <= 1'b1;
                            rsp_data  <= link_data;
                            rsp_fail  <= 1'b0;
                        end else begin
                            link_vld  <= 1'b1;
                            link_addr <= req_addr;
                            link_long <= req_long;
                            fill_link <= 1'b1;
                            pkt_op    <= OP_RD;
                            nflit     <= 1;
                            for (int i = 0; i < MAX_FLITS; i++) fbuf[i] <= '0;
                            st        <= S_SEND;
                        end
                        OP_SC: begin
                            link_vld <= 1'b0;
                            if (hit) begin
                                pkt_op  <= OP_SC;
                                fbuf[0] <= link_data[WORD_W-1:0];
                                if (req_long) begin
                                    fbuf[1] <= link_data[63:WORD_W];
                                    fbuf[2] <= req_wdata[WORD_W-1:0];
                                    fbuf[3] <= req_wdata[63:WORD_W];
                                    nflit   <= 4;
                                end else begin
                                    fbuf[1] <= req_wdata[WORD_W-1:0];
                                    fbuf[2] <= '0;
                                    fbuf[3] <= '0;
                                    nflit   <= 2;
                                end
                                st <= S_SEND;
                            end else begin
                                rsp_valid <= 1'b1;
                                rsp_data  <= '0;
                                rsp_fail  <= 1'b1;
                            end
                        end
                        OP_WR: begin
                            pkt_op  <= OP_WR;
                            fbuf[0] <= req_wdata[WORD_W-1:0];
                            fbuf[1] <= req_wdata[63:WORD_W];
                            fbuf[2] <= '0;
                            fbuf[3] <= '0;
                            nflit   <= req_long ? 2 : 1;
                            st      <= S_SEND;
                        end
                        default: begin
                            pkt_op <= OP_RD;
                            nflit  <= 1;
                            for (int i = 0; i < MAX_FLITS; i++) fbuf[i] <= '0;
                            st     <= S_SEND;
                        end
                    endcase
                end
                S_SEND: begin
                    if (pkt_last) begin
                        fidx <= '0;
                        st   <= S_WAIT;
                    end else begin
                        fidx <= fidx + 1'b1;
                    end
                end
                S_WAIT: if (mrsp_valid) begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= mrsp_data;
                    rsp_fail  <= mrsp_fail;
                    if (fill_link) link_data <= mrsp_data;
                    st <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    AST_SC_DROPS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_op == OP_SC) |=> !link_vld); // R5
    AST_SC_MISS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_op == OP_SC && !hit) |=> (!pkt_valid && rsp_valid && rsp_fail)); // R4
    AST_LL_HIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_op == OP_LL && hit) |=> (!pkt_valid && rsp_valid)); // R2
    AST_PLAIN_KEEPS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_op[1]) |=> $stable(link_vld)); // R8
endmodule

// File: rtl/mem_cmp_store.sv
// Memory half: collects packet flits, reads the addressed word pair
// with one cycle of latency, then reads, stores or compares-and-stores
// in one state, so nothing can interleave with a compare.
// Assumes flits of one packet arrive with stable op, addr and width.
module mem_cmp_store
    import cmpsc_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    input  logic [1:0]        pkt_op,
    input  logic [AW-1:0]     pkt_addr,
    input  logic              pkt_long,
    input  logic              pkt_last,
    input  logic [WORD_W-1:0] pkt_data,
    output logic              mrsp_valid,
    output logic [63:0]       mrsp_data,
    output logic              mrsp_fail
);
    localparam int DEPTH = 1 << AW;
    localparam int IW    = $clog2(MAX_FLITS);

    typedef enum logic [1:0] {M_COLL, M_LOOK, M_CHECK} mst_e;

    mst_e              mst;
    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] fb [MAX_FLITS];
    logic [IW-1:0]     fcnt;
    logic [1:0]        op_q;
    logic [AW-1:0]     addr_q;
    logic              long_q;
    logic [WORD_W-1:0] rd_lo, rd_hi;
    logic              same;

    // Old-data compare over one or both halves.
    assign same = (rd_lo == fb[0]) && (!long_q || (rd_hi == fb[1]));

    // Flit collection, word-pair read and atomic decide/store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mst        <= M_COLL;
            fcnt       <= '0;
            op_q       <= OP_RD;
            addr_q     <= '0;
            long_q     <= 1'b0;
            rd_lo      <= '0;
            rd_hi      <= '0;
            mrsp_valid <= 1'b0;
            mrsp_data  <= '0;
            mrsp_fail  <= 1'b0;
            for (int i = 0; i < MAX_FLITS; i++) fb[i] <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            mrsp_valid <= 1'b0;
            case (mst)
                M_COLL: if (pkt_valid) begin
                    fb[fcnt] <= pkt_data;
                    op_q     <= pkt_op;
                    addr_q   <= pkt_addr;
                    long_q   <= pkt_long;
                    if (pkt_last) begin
                        fcnt <= '0;
                        mst  <= M_LOOK;
                    end else begin
                        fcnt <= fcnt + 1'b1;
                    end
                end
                M_LOOK: begin
                    rd_lo <= mem[addr_q];
                    rd_hi <= mem[addr_q + 1'b1];
                    mst   <= M_CHECK;
                end
                M_CHECK: begin
                    mrsp_valid <= 1'b1;
                    mrsp_data  <= '0;
                    mrsp_fail  <= 1'b0;
                    case (op_e'(op_q))
                        OP_RD: mrsp_data <= {long_q ? rd_hi : '0, rd_lo};
                        OP_WR: begin
                            mem[addr_q] <= fb[0];
                            if (long_q) mem[addr_q + 1'b1] <= fb[1];
                        end
                        OP_SC: begin
                            mrsp_fail <= !same;
                            if (same) begin
                                mem[addr_q] <= long_q ? fb[2] : fb[1];
                                if (long_q) mem[addr_q + 1'b1] <= fb[3];
                            end
                        end
                        default: mrsp_data <= '0;
                    endcase
                    mst <= M_COLL;
                end
                default: mst <= M_COLL;
            endcase
        end
    end

    AST_SC_PKT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mst == M_COLL && pkt_valid && pkt_last && pkt_op == OP_SC)
            |-> (fcnt == (pkt_long ? 2'd3 : 2'd1))); // R6
    AST_FAIL_FROM_SC: assert property (@(posedge clk) disable iff (!rst_n)
        (mrsp_valid && mrsp_fail) |-> (op_q == OP_SC)); // R7
    AST_MISMATCH_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (mst == M_CHECK && op_q == OP_SC && rd_lo != fb[0]) |=> (mrsp_valid && mrsp_fail)); // R7
endmodule

// File: rtl/cmp_sc_unit.sv
// Top: joins the requester half and the memory half over the flit
// channel, which is also brought out for observation.
module cmp_sc_unit
    import cmpsc_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic          req_long,
    input  logic [AW-1:0] req_addr,
    input  logic [63:0]   req_wdata,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [63:0]   rsp_data,
    output logic          rsp_fail,
    output logic          pkt_valid,
    output logic          pkt_last,
    output logic [31:0]   pkt_data
);
    logic [1:0]    pkt_op;
    logic [AW-1:0] pkt_addr;
    logic          pkt_long;
    logic          mrsp_valid;
    logic [63:0]   mrsp_data;
    logic          mrsp_fail;

    ll_link_unit #(.AW(AW)) u_req (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_long(req_long),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_fail(rsp_fail),
        .pkt_valid(pkt_valid), .pkt_op(pkt_op), .pkt_addr(pkt_addr),
        .pkt_long(pkt_long), .pkt_last(pkt_last), .pkt_data(pkt_data),
        .mrsp_valid(mrsp_valid), .mrsp_data(mrsp_data), .mrsp_fail(mrsp_fail)
    );

    mem_cmp_store #(.AW(AW)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .pkt_valid(pkt_valid), .pkt_op(pkt_op), .pkt_addr(pkt_addr),
        .pkt_long(pkt_long), .pkt_last(pkt_last), .pkt_data(pkt_data),
        .mrsp_valid(mrsp_valid), .mrsp_data(mrsp_data), .mrsp_fail(mrsp_fail)
    );
endmodule

// File: tb/test_cmp_sc_unit.sv
module test_cmp_sc_unit;
    localparam int AW = 6;

    typedef struct packed {
        logic [1:0]  op;
        logic        lng;
        logic [5:0]  addr;
        logic [63:0] wd;
        logic [63:0] ed;
        logic        ef;
        logic [2:0]  nf;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        '{2'd2, 1'b0, 6'd4,  64'h11, 64'h0, 1'b0, 3'd1},
        '{2'd0, 1'b0, 6'd4,  64'h0, 64'h11, 1'b0, 3'd1},
        '{2'd0, 1'b0, 6'd4,  64'h0, 64'h11, 1'b0, 3'd0},
        '{2'd1, 1'b0, 6'd4,  64'h22, 64'h0, 1'b0, 3'd2},
        '{2'd0, 1'b0, 6'd4,  64'h0, 64'h22, 1'b0, 3'd1},
        '{2'd2, 1'b0, 6'd4,  64'h33, 64'h0, 1'b0, 3'd1},
        '{2'd0, 1'b0, 6'd4,  64'h0, 64'h22, 1'b0, 3'd0},
        '{2'd1, 1'b0, 6'd4,  64'h44, 64'h0, 1'b1, 3'd2},
        '{2'd1, 1'b0, 6'd4,  64'h55, 64'h0, 1'b1, 3'd0},
        '{2'd3, 1'b0, 6'd4,  64'h0, 64'h33, 1'b0, 3'd1},
        '{2'd0, 1'b0, 6'd4,  64'h0, 64'h33, 1'b0, 3'd1},
        '{2'd1, 1'b0, 6'd8,  64'h1, 64'h0, 1'b1, 3'd0},
        '{2'd1, 1'b0, 6'd4,  64'h66, 64'h0, 1'b1, 3'd0},
        '{2'd2, 1'b1, 6'd10, 64'hAAAA0000_BBBB0001, 64'h0, 1'b0, 3'd2},
        '{2'd0, 1'b1, 6'd10, 64'h0, 64'hAAAA0000_BBBB0001, 1'b0, 3'd1},
        '{2'd2, 1'b0, 6'd11, 64'h123, 64'h0, 1'b0, 3'd1},
        '{2'd1, 1'b1, 6'd10, 64'h1111, 64'h0, 1'b1, 3'd4},
        '{2'd0, 1'b1, 6'd10, 64'h0, 64'h00000123_BBBB0001, 1'b0, 3'd1},
        '{2'd1, 1'b1, 6'd10, 64'hCAFEF00D_12345678, 64'h0, 1'b0, 3'd4},
        '{2'd0, 1'b1, 6'd10, 64'h0, 64'hCAFEF00D_12345678, 1'b0, 3'd1},
        '{2'd2, 1'b1, 6'd10, 64'hCAFEF00D_12345678, 64'h0, 1'b0, 3'd2},
        '{2'd1, 1'b1, 6'd10, 64'h9, 64'h0, 1'b0, 3'd4},
        '{2'd0, 1'b0, 6'd4,  64'h0, 64'h33, 1'b0, 3'd1},
        '{2'd0, 1'b1, 6'd10, 64'h0, 64'h9, 1'b0, 3'd1},
        '{2'd1, 1'b0, 6'd4,  64'h77, 64'h0, 1'b1, 3'd0},
        '{2'd3, 1'b0, 6'd4,  64'h0, 64'h33, 1'b0, 3'd1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = '0;
    logic          req_long = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [63:0]   req_wdata = '0;
    logic          req_ready, rsp_valid, rsp_fail, pkt_valid, pkt_last;
    logic [63:0]   rsp_data;
    logic [31:0]   pkt_data;

    int            n_chk = 0;
    int            n_bad = 0;
    int            cyc = 0;
    int            flit_n = 0;
    logic [31:0]   flit_log [8];
    logic [63:0]   got_data;
    logic          got_fail;
    logic          got_rsp;

    cmp_sc_unit #(.AW(AW)) i_cmp_sc_unit (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_long(req_long),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_fail(rsp_fail),
        .pkt_valid(pkt_valid), .pkt_last(pkt_last), .pkt_data(pkt_data)
    );

    always #10 clk = ~clk;

    // Flit monitor, sampled away from the active edge.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (pkt_valid) begin
            if (flit_n < 8) flit_log[flit_n] = pkt_data;
            flit_n = flit_n + 1;
        end
        if (cyc > 20000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 20000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [1:0] op, input logic lng, input logic [AW-1:0] a,
                         input logic [63:0] wd);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        flit_n    = 0;
        req_valid = 1'b1;
        req_op    = op;
        req_long  = lng;
        req_addr  = a;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        got_rsp   = 1'b0;
        for (int k = 0; k < 40 && !got_rsp; k++) begin
            if (rsp_valid) begin
                got_rsp  = 1'b1;
                got_data = rsp_data;
                got_fail = rsp_fail;
            end else begin
                @(negedge clk);
            end
        end
        if (!got_rsp) begin
            got_data = 'x;
            got_fail = 1'bx;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state seen at the ports
        check("R1 ready", {63'd0, req_ready}, 64'd1);
        check("R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);
        check("R1 pkt_valid", {63'd0, pkt_valid}, 64'd0);
        rst_n = 1'b1;
        do_op(2'd1, 1'b0, 6'd4, 64'h5);
        check("R1 sc after reset fails", {63'd0, got_fail}, 64'd1);
        check("R1 sc after reset no flits", 64'(flit_n), 64'd0);
        do_op(2'd3, 1'b1, 6'd4, 64'h0);
        check("R1 memory cleared", got_data, 64'd0);

        // Vector table: R2 R3 R4 R5 R7 R8 R9 scenarios
        for (int v = 0; v < NV; v++) begin
            do_op(VEC[v].op, VEC[v].lng, VEC[v].addr, VEC[v].wd);
            check($sformatf("R4 R7 vec %0d data", v), got_data, VEC[v].ed);
            check($sformatf("R7 vec %0d fail bit", v), {63'd0, got_fail}, {63'd0, VEC[v].ef});
            check($sformatf("R2 R3 R9 vec %0d flit count", v), 64'(flit_n), 64'(VEC[v].nf));
        end

        // R6: 64-bit packet order old-low, old-high, new-low, new-high
        do_op(2'd2, 1'b1, 6'd20, 64'h00000002_00000001);
        do_op(2'd0, 1'b1, 6'd20, 64'h0);
        do_op(2'd1, 1'b1, 6'd20, 64'h00000004_00000003);
        check("R6 long flits", 64'(flit_n), 64'd4);
        for (int f = 0; f < 4; f++)
            check($sformatf("R6 long flit %0d", f), 64'(flit_log[f]), 64'(f + 1));
        check("R7 long success", {63'd0, got_fail}, 64'd0);
        do_op(2'd3, 1'b1, 6'd20, 64'h0);
        check("R7 long stored", got_data, 64'h00000004_00000003);

        // R6: 32-bit packet order old, new
        do_op(2'd0, 1'b0, 6'd30, 64'h0);
        do_op(2'd1, 1'b0, 6'd30, 64'hBEEF);
        check("R6 short flit 0", 64'(flit_log[0]), 64'h0);
        check("R6 short flit 1", 64'(flit_log[1]), 64'hBEEF);

        // R5: width mismatch after a long link counts as a miss, link gone
        do_op(2'd0, 1'b1, 6'd20, 64'h0);
        do_op(2'd1, 1'b0, 6'd20, 64'h7);
        check("R5 width mismatch fails", {63'd0, got_fail}, 64'd1);
        do_op(2'd0, 1'b1, 6'd20, 64'h0);
        check("R5 link cleared by failed sc", 64'(flit_n), 64'd1);

        // R1: reset in the middle drops the link
        do_op(2'd0, 1'b0, 6'd4, 64'h0);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        do_op(2'd1, 1'b0, 6'd4, 64'h1);
        check("R1 link empty after reset", {63'd0, got_fail}, 64'd1);
        check("R1 no flits after reset", 64'(flit_n), 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule